// File: doc/BRIEF.md
# Idle-Locked Serial Stream Descrambler

This block sits on the receive path of a 100 Mb/s twisted-pair link, after line decoding has produced one recovered bit per clock together with a valid strobe. It removes the remote transmitter's scrambling so that later stages see plain 5-bit code groups. The unscrambled idle pattern is all ones, so while the line idles the block learns the remote key. It treats each received bit as the complement of the keystream bit and predicts the following bit from what it has learned so far.

When enough predictions in a row are correct, the key is frozen and runs freely as a local generator. Every later bit is descrambled against it. The first idle run seen after lock fixes the code-group boundary. From then on a group strobe marks each run of five descrambled bits.

A watchdog guards the lock. If no idle run appears for a window of several thousand byte times, the block declares the receive broken. It drops lock, pulses an abort flag and returns to acquisition. The default window is long enough for the longest legal frame to pass.

Top module: `idle_lock_descrambler`

## Requirements
- R1: A synchronous active-high reset clears the key, all counters and the lock state. After reset, `locked`, `grp_vld` and `rx_abort` read 0.
- R2: While locked, each valid output bit is the received bit XOR (key[10] XOR key[8]). The 11-bit key (polynomial x^11 + x^9 + 1) then shifts left by one, taking that same XOR result into key[0].
- R3: While unlocked, each valid bit shifts its complement into key[0]. A bit counts as a correct prediction when the received bit XOR (key[10] XOR key[8]) is 1. After 30 consecutive correct predictions, `locked` reads 1 in the cycle after the 30th such bit.
- R4: An incorrect prediction during acquisition restarts the run of correct predictions from zero.
- R5: Cycles with `rx_vld` low have no effect on the key, the counters, the lock state or the group outputs, whatever `rx_bit` carries.
- R6: After lock, the first run of 10 consecutive descrambled ones sets the group boundary. The next valid bit becomes bit 4 (MSB) of the first group, and later bits fill toward bit 0. `grp_vld` pulses for one cycle, one cycle after every fifth valid bit, with the group on `grp_data`.
- R7: Each valid descrambled one that ends a run of 10 or more ones restarts the watchdog. Such later runs do not move the group boundary.
- R8: If WDOG_BYTES*8 consecutive valid bits pass while locked without restarting the watchdog, `locked` falls to 0 and `rx_abort` is 1 for exactly one cycle. Both happen in the cycle after the last of those bits.
- R9: After an abort, `grp_vld` stays 0 until lock is regained and a new boundary is set. Acquisition restarts and can lock again on idle.
- R10: By default the watchdog window is 4000 bytes (32000 valid bits): the abort follows the 32000th bit after lock that carries no idle run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Recovered serial bit, still scrambled |
| rx_vld | input | 1 | Qualifies `rx_bit` for this cycle |
| grp_data | output | 5 | Descrambled code group, first-received bit in bit 4 |
| grp_vld | output | 1 | One-cycle strobe for `grp_data` |
| locked | output | 1 | Key is synchronized and frozen |
| rx_abort | output | 1 | One-cycle pulse when the watchdog drops lock |

## Verification
The assertions check on every cycle that an abort lasts one cycle and coincides with a fall of `locked`. They also check that lock is only ever gained on a valid bit, that group strobes never come back to back, and that no group is presented while unlocked. Whether the key is learned correctly, whether groups carry the right descrambled bits at the right boundary, and whether the watchdog fires on exactly the right bit can only be shown by the bench. It runs several remote keys through idle, frames, gaps in the valid strobe, a prediction error during acquisition, a watchdog expiry with relock, and the full default window.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic {
    SYNC_ACQ  = 1'b0,
    SYNC_LOCK = 1'b1
  } sync_state_e;
endpackage

// File: rtl/dsc_key.sv
// Key register: learns from idle while unlocked, then runs free as an LFSR.
module dsc_key #(
  parameter int KEY_W  = 11,
  parameter int TAP_HI = 10,
  parameter int TAP_LO = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic rx_bit,
  input  logic lock_q,
  output logic plain
);
  logic [KEY_W-1:0] key;
  logic             ks;

  assign ks    = key[TAP_HI] ^ key[TAP_LO];
  assign plain = rx_bit ^ ks;

  always_ff @(posedge clk) begin
    if (rst) begin
      key <= '0;
    end else if (vld) begin
      // locked: free-running generator; unlocked: idle implies keystream = ~rx
      key <= {key[KEY_W-2:0], lock_q ? ks : ~rx_bit};
    end
  end
endmodule

// File: rtl/dsc_sync.sv
// Acquisition counter, lock state, idle-run detector and watchdog.
module dsc_sync
  import dsc_pkg::*;
#(
  parameter int LOCK_RUN  = 30,
  parameter int IDLE_RUN  = 10,
  parameter int WDOG_BITS = 32000
) (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic plain,
  output logic lock_q,
  output logic abort_q,
  output logic aligned_q,
  output logic first_hit,
  output logic drop
);
  localparam int AW = $clog2(LOCK_RUN + 1);
  localparam int RW = $clog2(IDLE_RUN + 1);
  localparam int WW = $clog2(WDOG_BITS + 1);
  localparam logic [AW-1:0] ACQ_LAST = AW'(LOCK_RUN - 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(IDLE_RUN - 1);
  localparam logic [WW-1:0] WD_LAST  = WW'(WDOG_BITS - 1);

  sync_state_e   state;
  logic [AW-1:0] acq_cnt;
  logic [RW-1:0] run_cnt;
  logic [WW-1:0] wd_cnt;
  logic          idle_hit;
  logic          in_lock;

  assign in_lock   = (state == SYNC_LOCK);
  assign lock_q    = in_lock;
  assign idle_hit  = vld && in_lock && plain && (run_cnt == RUN_LAST);
  assign drop      = vld && in_lock && !idle_hit && (wd_cnt == WD_LAST);
  assign first_hit = idle_hit && !aligned_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SYNC_ACQ;
      acq_cnt   <= '0;
      run_cnt   <= '0;
      wd_cnt    <= '0;
      aligned_q <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      if (vld) begin
        if (!in_lock) begin
          if (plain) begin
            if (acq_cnt == ACQ_LAST) begin
              state     <= SYNC_LOCK;
              acq_cnt   <= '0;
              run_cnt   <= '0;
              wd_cnt    <= '0;
              aligned_q <= 1'b0;
            end else begin
              acq_cnt <= acq_cnt + 1'b1;
            end
          end else begin
            acq_cnt <= '0;
          end
        end else if (drop) begin
          state     <= SYNC_ACQ;
          abort_q   <= 1'b1;
          aligned_q <= 1'b0;
          run_cnt   <= '0;
          acq_cnt   <= '0;
          wd_cnt    <= '0;
        end else begin
          if (!plain)                  run_cnt <= '0;
          else if (run_cnt != RUN_LAST) run_cnt <= run_cnt + 1'b1;
          wd_cnt <= idle_hit ? '0 : wd_cnt + 1'b1;
          if (first_hit) aligned_q <= 1'b1;
        end
      end
    end
  end

  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    abort_q |=> !abort_q); // R8
  AST_ABORT_WITH_LOSS: assert property (@(posedge clk) disable iff (rst)
    abort_q |-> (!lock_q && $past(lock_q))); // R8
  AST_LOCK_ON_VALID: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(vld)); // R5
endmodule

// File: rtl/dsc_group.sv
// Serial-to-parallel framer with a realignable group counter.
module dsc_group #(
  parameter int GRP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             plain,
  input  logic             enable,
  input  logic             realign,
  output logic [GRP_W-1:0] grp_data,
  output logic             grp_vld
);
  localparam int CW = $clog2(GRP_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(GRP_W - 1);

  logic [CW-1:0]    cnt;
  logic [GRP_W-2:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      shreg    <= '0;
      grp_data <= '0;
      grp_vld  <= 1'b0;
    end else begin
      grp_vld <= 1'b0;
      if (vld) begin
        if (realign) begin
          cnt <= '0;
        end else if (enable) begin
          shreg <= {shreg[GRP_W-3:0], plain};
          if (cnt == CNT_LAST) begin
            grp_data <= {shreg, plain};
            grp_vld  <= 1'b1;
            cnt      <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  AST_GROUP_SPACING: assert property (@(posedge clk) disable iff (rst)
    grp_vld |=> !grp_vld); // R6
endmodule

// File: rtl/idle_lock_descrambler.sv
module idle_lock_descrambler #(
  parameter int KEY_W         = 11,
  parameter int TAP_HI        = 10,
  parameter int TAP_LO        = 8,
  parameter int LOCK_RUN      = 30,
  parameter int IDLE_RUN      = 10,
  parameter int WDOG_BYTES    = 4000,
  parameter int BITS_PER_BYTE = 8,
  parameter int GRP_W         = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_bit,
  input  logic             rx_vld,
  output logic [GRP_W-1:0] grp_data,
  output logic             grp_vld,
  output logic             locked,
  output logic             rx_abort
);
  localparam int WDOG_BITS = WDOG_BYTES * BITS_PER_BYTE;

  logic plain;
  logic lock_q;
  logic aligned_q;
  logic first_hit;
  logic drop;
  logic grp_en;

  dsc_key #(
    .KEY_W (KEY_W),
    .TAP_HI(TAP_HI),
    .TAP_LO(TAP_LO)
  ) u_key (
    .clk   (clk),
    .rst   (rst),
    .vld   (rx_vld),
    .rx_bit(rx_bit),
    .lock_q(lock_q),
    .plain (plain)
  );

  dsc_sync #(
    .LOCK_RUN (LOCK_RUN),
    .IDLE_RUN (IDLE_RUN),
    .WDOG_BITS(WDOG_BITS)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .vld      (rx_vld),
    .plain    (plain),
    .lock_q   (lock_q),
    .abort_q  (rx_abort),
    .aligned_q(aligned_q),
    .first_hit(first_hit),
    .drop     (drop)
  );

  assign grp_en = lock_q && aligned_q && !drop;

  dsc_group #(
    .GRP_W(GRP_W)
  ) u_group (
    .clk     (clk),
    .rst     (rst),
    .vld     (rx_vld),
    .plain   (plain),
    .enable  (grp_en),
    .realign (first_hit),
    .grp_data(grp_data),
    .grp_vld (grp_vld)
  );

  assign locked = lock_q;

  AST_GROUP_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    grp_vld |-> locked); // R9
endmodule

// File: tb/sim_idle_lock_descrambler.sv
module sim_idle_lock_descrambler;
  localparam int CLK_PERIOD = 8;
  localparam int LOCK_RUN   = 30;
  localparam int IDLE_RUN   = 10;
  localparam int WD_BYTES   = 15;
  localparam int WD_BITS    = WD_BYTES * 8;
  localparam int GW         = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0, bit_vld = 1'b0;
  logic b1 = 1'b0, v1 = 1'b0;
  logic [GW-1:0] grp_data, grp_data1;
  logic grp_vld, locked, rx_abort;
  logic grp_vld1, locked1, rx_abort1;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_lock_descrambler #(
    .LOCK_RUN(LOCK_RUN), .IDLE_RUN(IDLE_RUN), .WDOG_BYTES(WD_BYTES)
  ) u0 (
    .clk(clk), .rst(rst), .rx_bit(bit_in), .rx_vld(bit_vld),
    .grp_data(grp_data), .grp_vld(grp_vld), .locked(locked), .rx_abort(rx_abort)
  );

  idle_lock_descrambler u1 (
    .clk(clk), .rst(rst), .rx_bit(b1), .rx_vld(v1),
    .grp_data(grp_data1), .grp_vld(grp_vld1), .locked(locked1), .rx_abort(rx_abort1)
  );

  int n_cmp = 0, n_bad = 0;

  // reference state derived from the requirements
  logic [10:0] tk, rk, tk1;
  logic        m_lock, m_aligned;
  int          streak, run, wd, gcnt;
  logic [3:0]  gsh;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    rk = '0; m_lock = 0; m_aligned = 0;
    streak = 0; run = 0; wd = 0; gcnt = 0; gsh = '0;
  endtask

  task automatic bench_reset();
    @(negedge clk); rst = 1; bit_vld = 0; v1 = 0;
    @(posedge clk); @(negedge clk); rst = 0;
    @(posedge clk); #1;
    model_clear();
    check("R1", "locked", 32'(locked), 0);
    check("R1", "grp_vld", 32'(grp_vld), 0);
    check("R1", "rx_abort", 32'(rx_abort), 0);
  endtask

  task automatic step(input logic d, input logic v, input string tag);
    logic r, kb, p, hit, drop, e_gv, e_ab;
    logic [4:0] e_gd;
    e_gv = 0; e_ab = 0; e_gd = '0;
    if (v) begin
      kb = tk[10] ^ tk[8]; r = d ^ kb; tk = {tk[9:0], kb};
    end else begin
      r = 1'($urandom);
    end
    @(negedge clk); bit_in = r; bit_vld = v;
    @(posedge clk); #1;
    if (v) begin
      kb = rk[10] ^ rk[8];
      p  = r ^ kb;
      if (!m_lock) begin
        rk = {rk[9:0], ~r};
        if (p) begin
          if (streak == LOCK_RUN - 1) begin
            m_lock = 1; streak = 0; run = 0; wd = 0; m_aligned = 0;
          end else streak++;
        end else streak = 0;
      end else begin
        rk = {rk[9:0], kb};
        hit  = p && (run == IDLE_RUN - 1);
        drop = !hit && (wd == WD_BITS - 1);
        if (drop) begin
          m_lock = 0; e_ab = 1; m_aligned = 0; streak = 0; run = 0; wd = 0;
        end else begin
          run = p ? ((run == IDLE_RUN - 1) ? run : run + 1) : 0;
          wd  = hit ? 0 : wd + 1;
          if (hit && !m_aligned) begin
            m_aligned = 1; gcnt = 0;
          end else if (m_aligned) begin
            if (gcnt == GW - 1) begin
              e_gv = 1; e_gd = {gsh, p}; gcnt = 0;
            end else gcnt++;
            gsh = {gsh[2:0], p};
          end
        end
      end
    end
    check(tag, "locked", 32'(locked), 32'(m_lock));
    check(tag, "rx_abort", 32'(rx_abort), 32'(e_ab));
    check(tag, "grp_vld", 32'(grp_vld), 32'(e_gv));
    if (e_gv) check(tag, "grp_data", 32'(grp_data), 32'(e_gd));
  endtask

  task automatic send_idle(input int n, input int gap, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, !(gap > 0 && (i % gap) == gap - 1), tag);
  endtask

  task automatic send_pat(input int n, input int kind, input string tag);
    for (int i = 0; i < n; i++)
      step(kind == 0 ? ((i % 3) == 0) : ((i % 4) != 3), 1'b1, tag);
  endtask

  task automatic step1(input logic d);
    logic kb;
    kb = tk1[10] ^ tk1[8];
    @(negedge clk); b1 = d ^ kb; v1 = 1;
    tk1 = {tk1[9:0], kb};
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [10:0] seeds [4];
    logic bad1;
    seeds[0] = 11'h001; seeds[1] = 11'h5A5; seeds[2] = 11'h7FF; seeds[3] = 11'h2C3;
    model_clear();
    bench_reset();

    for (int s = 0; s < 4; s++) begin
      bench_reset();
      tk = seeds[s];
      send_idle(70, 7, "R3");
      check("R3", "locked after idle", 32'(locked), 1);
      send_idle(15, 0, "R6");
      send_pat(100, s % 2, "R2");
      send_idle(12, 0, "R7");
      send_pat(100, 1, "R7");
      send_idle(12, 0, "R7");
      send_idle(30, 2, "R5");
      send_pat(WD_BITS + 10, 0, "R8");
      check("R8", "locked after silence", 32'(locked), 0);
      send_idle(80, 0, "R9");
      check("R9", "relocked", 32'(locked), 1);
      send_pat(40, 1, "R9");
    end

    // R4: a prediction error during acquisition
    bench_reset();
    tk = 11'h4B7;
    send_idle(25, 0, "R4");
    step(1'b0, 1'b1, "R4");
    send_idle(28, 0, "R4");
    check("R4", "still unlocked", 32'(locked), 0);
    send_idle(30, 0, "R4");

    // R5: long stretch of invalid cycles while locked
    send_idle(20, 0, "R5");
    for (int i = 0; i < 3 * WD_BITS; i++) step(1'b0, 1'b0, "R5");
    check("R5", "lock kept over gap", 32'(locked), 1);

    // R10: default window of 4000 bytes
    bench_reset();
    tk1 = 11'h3A1;
    for (int i = 0; i < 100 && !locked1; i++) step1(1'b1);
    check("R10", "default lock", 32'(locked1), 1);
    bad1 = 0;
    for (int i = 0; i < 31999; i++) begin
      step1(1'b0);
      if (rx_abort1 || !locked1) bad1 = 1;
    end
    check("R10", "early abort", 32'(bad1), 0);
    step1(1'b0);
    check("R10", "abort at 32000", 32'(rx_abort1), 1);
    check("R10", "lock lost at 32000", 32'(locked1), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule